// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from a single clock. Each channel divides its time into a fixed period of 256 steps. A 16-bit divider value sets how many clock cycles one step lasts. An 8-bit duty value sets how many of those steps, counted from the start of the period, drive the output high. A channel can take its step timing from another channel's divider instead of its own, which lets several outputs share one rate setting.

Software programs the block through a small register bus. The bus has a write strobe, a read strobe, a word address, write data and registered read data. Two mode registers hold the per-channel output enables, the force-high bypass bits and the counter run enables. Changes to a channel's duty setting, or to the divider it uses, take effect at once. The running period is abandoned and a new period starts on the next clock.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Register map by word address: 0 holds the output enables in bits [3:0] and the bypass bits in bits [11:8]; 1 holds the counter run enables in bits [3:0]; 2+n holds the divider of channel n in bits [15:0]; 6+n holds the duty of channel n in bits [7:0] and its divider select in bits [9:8]. A read returns the last value written, with unused bits as zero. Addresses 10 to 15 read as zero. `rdata` is updated on the clock edge where `rd_en` is high and holds between reads.
- R2: After a synchronous reset every register reads zero and all four outputs are low.
- R3: With divider D > 0 and duty U, a running enabled channel produces a period of D×256 cycles. Its output is high for the first D×U cycles of each period.
- R4: A channel whose output-enable bit is clear drives a low output, whatever its bypass bit, duty and divider hold. This applies from the cycle after the write that clears the bit.
- R5: An enabled channel whose bypass bit is set holds its output high continuously, even when its divider is zero.
- R6: The divider select of channel n (value k, 0 to 3) makes channel n time its steps with the divider of channel k.
- R7: Writing channel n's duty register, or writing the divider register its select points at, restarts channel n's period on that clock edge. The output is high in the next cycle whenever the new duty and divider are nonzero.
- R8: While a channel's counter run enable is clear, its counters hold, so its output stays at its current level until a register write changes it.
- R9: A channel whose selected divider is zero does not count, and its output is low unless bypass is set.
- R10: A duty of 0 gives a constant low output. A duty of 255 gives an output that is low for exactly D cycles per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register bus |
| rd_en | input | 1 | Read strobe for the register bus |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A wrong prescaler or step count shows at the ports as a wrong high time or period on `pwm_out`. It appears within one full period, which is at most D×256 cycles, so the bench measures the spacing of rising and falling edges over whole periods. A missed restart shows as early as the cycle after the write: the output stays low when it should go high. A register or enable fault shows on `rdata` one cycle after the read strobe, or as a wrong output level in the cycle after the mode write. Frozen-counter faults show as any output transition over a few hundred cycles while the run enable is clear.

// File: rtl/pwm_quad_pkg.sv
// Package: shared constants for the four-channel prescaled PWM.
// Assumes word addressing on the register bus; the map positions below are
// the ones software depends on.
package pwm_quad_pkg;
    localparam int NUM_CH_D     = 4;   // channel count
    localparam int DIV_W_D      = 16;  // divider width
    localparam int DUTY_W_D     = 8;   // duty width (period = 2**DUTY_W steps)
    localparam int DATA_W_D     = 32;  // bus data width
    localparam int ADDR_W_D     = 4;   // bus word-address width
    localparam int A_MODE_OUT   = 0;   // output enables and bypass bits
    localparam int A_MODE_CNT   = 1;   // counter run enables
    localparam int A_DIV_BASE   = 2;   // first divider register
    localparam int BP_LSB       = 8;   // bypass field position in mode register
endpackage

// File: rtl/pwm_quad_regs.sv
// Module: register file and bus decode for the PWM.
// Holds mode, divider, duty and select fields, returns registered read data,
// and raises a per-channel restart pulse when a write touches the duty
// register of a channel or the divider that channel currently selects.
// Assumes at most one access per cycle; writes take effect on the clock edge.
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_D,
    parameter int DIV_W  = DIV_W_D,
    parameter int DUTY_W = DUTY_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int ADDR_W = ADDR_W_D,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  rdata,
    output logic [NUM_CH-1:0]                  out_en,
    output logic [NUM_CH-1:0]                  bypass,
    output logic [NUM_CH-1:0]                  cnt_en,
    output logic [NUM_CH-1:0][DIV_W-1:0]       div_all,
    output logic [NUM_CH-1:0][DUTY_W-1:0]      duty_all,
    output logic [NUM_CH-1:0][SEL_W-1:0]       sel_all,
    output logic [NUM_CH-1:0]                  restart
);
    localparam int DUTY_BASE = A_DIV_BASE + NUM_CH;
    localparam int SEL_LSB   = DUTY_W;

    logic [DATA_W-1:0] rd_val;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    // Register writes: each field updates only on a write to its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= '0;
            bypass   <= '0;
            cnt_en   <= '0;
            div_all  <= '0;
            duty_all <= '0;
            sel_all  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MODE_OUT)) begin
                out_en <= wdata[NUM_CH-1:0];
                bypass <= wdata[BP_LSB +: NUM_CH];
            end
            if (addr == ADDR_W'(A_MODE_CNT)) begin
                cnt_en <= wdata[NUM_CH-1:0];
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr == ADDR_W'(A_DIV_BASE + n)) begin
                    div_all[n] <= wdata[DIV_W-1:0];
                end
                if (addr == ADDR_W'(DUTY_BASE + n)) begin
                    duty_all[n] <= wdata[DUTY_W-1:0];
                    sel_all[n]  <= wdata[SEL_LSB +: SEL_W];
                end
            end
        end
    end

    // Read mux: assemble the addressed register with unused bits at zero.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(A_MODE_OUT)) begin
            rd_val[NUM_CH-1:0]        = out_en;
            rd_val[BP_LSB +: NUM_CH]  = bypass;
        end
        if (addr == ADDR_W'(A_MODE_CNT)) begin
            rd_val[NUM_CH-1:0] = cnt_en;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(A_DIV_BASE + n)) begin
                rd_val[DIV_W-1:0] = div_all[n];
            end
            if (addr == ADDR_W'(DUTY_BASE + n)) begin
                rd_val[DUTY_W-1:0]         = duty_all[n];
                rd_val[SEL_LSB +: SEL_W]   = sel_all[n];
            end
        end
    end

    // Read data register: capture on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    // Restart detect: own duty write, or write to the divider this channel uses.
    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            restart[n] = wr_en &&
                ((addr == ADDR_W'(DUTY_BASE + n)) ||
                 (addr == ADDR_W'(A_DIV_BASE) + ADDR_W'(sel_all[n])));
        end
    end
endmodule

// File: rtl/pwm_quad_divsel.sv
// Module: divider crossbar.
// Gives each channel the divider value of the channel its select field names.
// Assumes select values at or above NUM_CH mean "no divider" (reads zero).
module pwm_quad_divsel #(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 16,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0][DIV_W-1:0] div_all,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel_all,
    output logic [NUM_CH-1:0][DIV_W-1:0] eff_div
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_mux
        // Per-channel select: pick the named divider or zero if out of range.
        assign eff_div[g] = (int'(sel_all[g]) < NUM_CH) ? div_all[sel_all[g]] : '0;
    end
endmodule

// File: rtl/pwm_quad_chan.sv
// Module: one PWM channel.
// A prescaler counts DIV cycles per step; a step counter wraps every
// 2**DUTY_W steps. Output is high while the step count is below the duty.
// Assumes restart and a zero divider both park the counters at zero.
module pwm_quad_chan #(
    parameter int DIV_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic              bypass,
    input  logic              cnt_en,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_o
);
    logic [DIV_W-1:0]  pre_q;
    logic [DUTY_W-1:0] step_q;
    logic              running;
    logic              step_end;

    assign running  = (div != '0);
    assign step_end = (pre_q >= div - DIV_W'(1));

    // Counters: restart or stop clears, run enable advances, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !running) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (cnt_en) begin
            if (step_end) begin
                pre_q  <= '0;
                step_q <= step_q + DUTY_W'(1);
            end else begin
                pre_q  <= pre_q + DIV_W'(1);
            end
        end
    end

    // Output: enable gates everything, bypass forces high, else compare.
    assign pwm_o = out_en && (bypass || (running && (step_q < duty)));
endmodule

// File: rtl/pwm_quad_ctrl.sv
// Module: top of the four-channel prescaled PWM.
// Connects the register file, the divider crossbar and one channel per
// output. Assumes a single clock domain and synchronous active-low reset.
module pwm_quad_ctrl
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_D,
    parameter int DIV_W  = DIV_W_D,
    parameter int DUTY_W = DUTY_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0]              out_en_w;
    logic [NUM_CH-1:0]              bypass_w;
    logic [NUM_CH-1:0]              cnt_en_w;
    logic [NUM_CH-1:0]              restart_w;
    logic [NUM_CH-1:0][DIV_W-1:0]   div_all_w;
    logic [NUM_CH-1:0][DIV_W-1:0]   eff_div_w;
    logic [NUM_CH-1:0][DUTY_W-1:0]  duty_all_w;
    logic [NUM_CH-1:0][SEL_W-1:0]   sel_all_w;

    pwm_quad_regs #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .DUTY_W(DUTY_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .out_en   (out_en_w),
        .bypass   (bypass_w),
        .cnt_en   (cnt_en_w),
        .div_all  (div_all_w),
        .duty_all (duty_all_w),
        .sel_all  (sel_all_w),
        .restart  (restart_w)
    );

    pwm_quad_divsel #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .SEL_W(SEL_W)
    ) u_divsel (
        .div_all (div_all_w),
        .sel_all (sel_all_w),
        .eff_div (eff_div_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_quad_chan #(
            .DIV_W(DIV_W), .DUTY_W(DUTY_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .out_en  (out_en_w[g]),
            .bypass  (bypass_w[g]),
            .cnt_en  (cnt_en_w[g]),
            .restart (restart_w[g]),
            .div     (eff_div_w[g]),
            .duty    (duty_all_w[g]),
            .pwm_o   (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
// Module: assertion checker for the PWM, attached to the top by bind.
// Observes bus ports, outputs and the decoded mode/divider state.
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 16,
    parameter int DUTY_W = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic [DATA_W-1:0]            rdata,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            out_en,
    input logic [NUM_CH-1:0]            bypass,
    input logic [NUM_CH-1:0]            cnt_en,
    input logic [NUM_CH-1:0][DIV_W-1:0] eff_div
);
    localparam int DUTY_BASE = A_DIV_BASE + NUM_CH;
    localparam int NUM_REGS  = DUTY_BASE + NUM_CH;

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0)); // R2

    AST_CNT_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_MODE_CNT)) |=> (rdata[DATA_W-1:NUM_CH] == '0)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) >= NUM_REGS) |=> (rdata == '0)); // R1

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(A_MODE_OUT) && !wdata[g]) |=> !pwm_out[g]); // R4

        AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(A_MODE_OUT) && wdata[g] && wdata[BP_LSB + g])
            |=> pwm_out[g]); // R5

        AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(DUTY_BASE + g) && wdata[DUTY_W-1:0] != '0 && out_en[g])
            |=> (pwm_out[g] || eff_div[g] == '0)); // R7

        AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_en[g] && !wr_en) |=> $stable(pwm_out[g])); // R8

        AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_div[g] == '0 && !bypass[g]) |-> !pwm_out[g]); // R9
    end
endmodule

bind pwm_quad_ctrl pwm_quad_chk #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .DUTY_W(DUTY_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out),
    .out_en  (out_en_w),
    .bypass  (bypass_w),
    .cnt_en  (cnt_en_w),
    .eff_div (eff_div_w)
);

// File: tb/pwm_quad_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_quad_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        int    ch;
        int    hi;
        int    per;
        string tag;
    } wave_t;
    wave_t sb_q[$];
    int    sb_done = 0;

    always #2.5 clk = ~clk;

    pwm_quad_ctrl u_pwm_quad_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == exp, tag, rdata, exp);
    endtask

    // Hold check: count samples that differ from a fixed level.
    task automatic hold_chk(input int ch, input int cycles, input bit lvl, input string tag);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic wait_fall(input int ch);
        bit p = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (p && !pwm_out[ch]) break;
            p = pwm_out[ch];
        end
    endtask

    task automatic wait_rise(input int ch);
        bit p = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!p && pwm_out[ch]) break;
            p = pwm_out[ch];
        end
    endtask

    // Driver side of the scoreboard: queue an expected shape and wait for it.
    task automatic expect_wave(input int ch, input int hi, input int per, input string tag);
        wave_t it;
        int target;
        it.ch = ch; it.hi = hi; it.per = per; it.tag = tag;
        target = sb_done + 1;
        sb_q.push_back(it);
        while (sb_done < target) @(negedge clk);
    endtask

    // Monitor: pop an expected shape, measure one period from a rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                wave_t it;
                int hi;
                int lo;
                it = sb_q.pop_front();
                wait_rise(it.ch);
                hi = 1;
                @(negedge clk);
                while (pwm_out[it.ch]) begin hi++; @(negedge clk); end
                lo = 1;
                @(negedge clk);
                while (!pwm_out[it.ch]) begin lo++; @(negedge clk); end
                check(hi == it.hi, {it.tag, " high time"}, hi, it.hi);
                check(hi + lo == it.per, {it.tag, " period"}, hi + lo, it.per);
                sb_done++;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check(pwm_out == 4'h0, "R2 outputs low after reset", pwm_out, 0);
        for (int a = 0; a < 10; a++) bus_rd_chk(a, 32'h0, "R2 register zero after reset");

        // R1: readback masks and unmapped space
        for (int a = 0; a < 10; a++) bus_wr(a, 32'hFFFF_FFFF);
        bus_rd_chk(0, 32'h0000_0F0F, "R1 mode-out mask");
        bus_rd_chk(1, 32'h0000_000F, "R1 run-enable mask");
        bus_rd_chk(3, 32'h0000_FFFF, "R1 divider mask");
        bus_rd_chk(8, 32'h0000_03FF, "R1 duty/select mask");
        bus_rd_chk(12, 32'h0, "R1 unmapped reads zero");
        for (int a = 0; a < 10; a++) bus_wr(a, 32'h0);
        bus_rd_chk(7, 32'h0, "R1 rewrite zero");

        // R3, R6, R10: steady waveforms
        bus_wr(2, 3);  bus_wr(3, 1);  bus_wr(4, 2);  bus_wr(5, 5);
        bus_wr(6, 64);
        bus_wr(7, 200 | (1 << 8));
        bus_wr(8, 255 | (2 << 8));
        bus_wr(9, 10);                      // ch3 borrows divider of ch0
        bus_wr(1, 32'hF);
        bus_wr(0, 32'hF);
        expect_wave(0, 192, 768, "R3 ch0 div3 duty64");
        expect_wave(1, 200, 256, "R3 ch1 div1 duty200");
        expect_wave(2, 510, 512, "R10 ch2 duty255 low for one step");
        expect_wave(3, 30, 768, "R6 ch3 uses ch0 divider");

        // R7: duty write restarts mid-period
        bus_wr(2, 4);
        bus_wr(6, 16);
        wait_fall(0);
        repeat (50) @(negedge clk);
        bus_wr(6, 32);
        begin
            int hi = 0;
            check(pwm_out[0] == 1'b1, "R7 output high right after duty write", pwm_out[0], 1);
            while (pwm_out[0]) begin hi++; @(negedge clk); end
            check(hi == 128, "R7 new high time after restart", hi, 128);
        end

        // R7: write to the borrowed divider restarts the borrowing channel
        wait_fall(3);
        repeat (20) @(negedge clk);
        bus_wr(2, 4);
        check(pwm_out[3] == 1'b1, "R7 divider write restarts ch3", pwm_out[3], 1);

        // R8: counters frozen while run enable is clear
        wait_rise(1);
        bus_wr(1, 32'hD);
        hold_chk(1, 300, 1'b1, "R8 ch1 frozen high");
        bus_wr(1, 32'hF);

        // R9: zero divider stops the channel low
        bus_wr(3, 0);
        hold_chk(1, 300, 1'b0, "R9 ch1 divider zero low");

        // R10: zero duty gives constant low
        bus_wr(6, 0);
        hold_chk(0, 600, 1'b0, "R10 ch0 duty zero low");

        // R4: cleared enable drives low
        bus_wr(0, 32'hB);
        hold_chk(2, 600, 1'b0, "R4 ch2 disabled low");

        // R5: bypass forces high, even with divider zero
        bus_wr(0, 32'hF | (32'h6 << 8));
        hold_chk(2, 600, 1'b1, "R5 ch2 bypass high");
        hold_chk(1, 50, 1'b1, "R5 ch1 bypass high with divider zero");

        // R4: bypass does not override a cleared enable
        bus_wr(0, 32'hD | (32'h2 << 8));
        hold_chk(1, 100, 1'b0, "R4 ch1 disabled despite bypass");

        finish_run();
    end
endmodule